// File: doc/BRIEF.md
# Serial Gamepad Auto-Read Engine

This block polls two serial game controller ports once per frame with no software help. When its vertical-blank trigger pulses and the auto-read enable is set, it raises a latch line shared by both ports, drops it again, and then strobes the clock of both ports together sixteen times. Before each clock strobe it samples the two data lines of each port. This fills four 16-bit result registers in parallel.

The controller data lines are active low. Every stored bit is the inverse of the pin, so a pressed button reads as 1. The sequence does not raise the latch again at its end, so the controllers keep their place in the bit stream and software can carry on with manual serial reads. Next to the sequencer sit the manual paths: a latch bit that drives the shared latch, and one serial read strobe per port. A manual read returns that port's current bits and then pulses that port's clock. The latch and clock strobe width is set by the parameter `HALF_CYC`.

Top module: `pad_autoread`

## Requirements
- R1: A sequence starts only when `vblank_start` is high, `autoread_en` is high and the block is idle. `busy` is high in the cycle after the trigger. A trigger while busy or while disabled has no effect.
- R2: The latch output is high for exactly `HALF_CYC` cycles and then low before the first clock strobe. Each port then gets exactly 16 clock pulses, on both ports at the same time, and the latch never overlaps a clock.
- R3: In each result the first bit read ends up in bit 15 and the last bit read in bit 0.
- R4: The data lines map to the results as follows: port 1 line 1 goes to `res_p1_l1`, port 2 line 1 to `res_p2_l1`, port 1 line 2 to `res_p1_l2`, and port 2 line 2 to `res_p2_l2`. On each pad input, bit 0 is line 1 and bit 1 is line 2.
- R5: Every stored bit is the logical inverse of the sampled pin.
- R6: `busy` stays high for exactly 2·HALF_CYC + 16·(2·HALF_CYC + 1) cycles.
- R7: The latch is not raised at the end of a sequence. The next manual read of a port returns stream bit 17, counting the first bit as 1.
- R8: A manual read of port p (`ser_rd[p]`) loads that port's read register in the next cycle and then gives that port's clock a single one-cycle pulse. In the read register, bit 0 is the inverted line 1 and bit 1 is the inverted line 2. The port 2 register holds 1 in bits 4:2. All other bits are 0.
- R9: `latch_wbit`, written with `latch_wr` while idle, drives `pad_latch` two cycles later.
- R10: Manual reads and latch writes made while busy are ignored. The read registers keep their values, no extra clock pulse is produced, and the latch bit stays unchanged.
- R11: After reset, `busy`, `pad_latch`, `pad_clk`, all results and both read registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vblank_start | input | 1 | One-cycle pulse at the start of vertical blank |
| autoread_en | input | 1 | Auto-read enable |
| latch_wr | input | 1 | Write strobe for the manual latch bit |
| latch_wbit | input | 1 | Value written to the manual latch bit |
| ser_rd | input | 2 | Manual serial read strobes, bit 0 for port 1 and bit 1 for port 2 |
| pad1_data_n | input | 2 | Port 1 data lines, active low |
| pad2_data_n | input | 2 | Port 2 data lines, active low |
| pad_latch | output | 1 | Shared controller latch |
| pad_clk | output | 2 | Per-port clock strobes |
| busy | output | 1 | High while the sequence runs |
| res_p1_l1 | output | 16 | Result for port 1, line 1 |
| res_p2_l1 | output | 16 | Result for port 2, line 1 |
| res_p1_l2 | output | 16 | Result for port 1, line 2 |
| res_p2_l2 | output | 16 | Result for port 2, line 2 |
| ser1_rdata | output | 8 | Manual read register for port 1 |
| ser2_rdata | output | 8 | Manual read register for port 2 |

## Verification
Faults in the bit counter or the state machine show up at once at the ports. The number of clock pulses per frame changes, and so does the length of `busy`. Because each result is then misaligned, the damage reaches every bit of a wrong word. A lane wiring or inversion fault corrupts one specific result by the end of the first frame. A stream position that is off shows up on the very first manual read after a sequence. Sweeping many distinct button patterns makes a stuck or swapped bit visible within a few frames.

// File: rtl/padrd_pkg.sv
package padrd_pkg;
  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_LATCH_HI,
    SQ_LATCH_LO,
    SQ_SAMPLE,
    SQ_CLK_HI,
    SQ_CLK_LO
  } seq_state_t;

  localparam int NUM_PORTS = 2;
  localparam int NUM_LINES = 2;
  localparam int NUM_LANES = NUM_PORTS * NUM_LINES;
endpackage

// File: rtl/padrd_seq.sv
module padrd_seq
  import padrd_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int BITS     = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trigger,
  input  logic enable,
  output logic busy,
  output logic seq_latch,
  output logic seq_clk,
  output logic sample
);
  localparam int CNT_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF_CYC - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS - 1);

  seq_state_t       st;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitn;
  logic             half_done;

  assign half_done = (cnt == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= SQ_IDLE;
      cnt  <= '0;
      bitn <= '0;
    end else begin
      case (st)
        SQ_IDLE: begin
          cnt  <= '0;
          bitn <= '0;
          if (trigger && enable) st <= SQ_LATCH_HI;
        end
        SQ_LATCH_HI: begin
          cnt <= half_done ? '0 : cnt + 1'b1;
          if (half_done) st <= SQ_LATCH_LO;
        end
        SQ_LATCH_LO: begin
          cnt <= half_done ? '0 : cnt + 1'b1;
          if (half_done) st <= SQ_SAMPLE;
        end
        SQ_SAMPLE: st <= SQ_CLK_HI;
        SQ_CLK_HI: begin
          cnt <= half_done ? '0 : cnt + 1'b1;
          if (half_done) st <= SQ_CLK_LO;
        end
        SQ_CLK_LO: begin
          cnt <= half_done ? '0 : cnt + 1'b1;
          if (half_done) begin
            if (bitn == BIT_LAST) begin
              st <= SQ_IDLE;
            end else begin
              bitn <= bitn + 1'b1;
              st   <= SQ_SAMPLE;
            end
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign busy      = (st != SQ_IDLE);
  assign seq_latch = (st == SQ_LATCH_HI);
  assign seq_clk   = (st == SQ_CLK_HI);
  assign sample    = (st == SQ_SAMPLE);
endmodule

// File: rtl/padrd_lane.sv
module padrd_lane #(
  parameter int BITS = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            pin_n,
  output logic [BITS-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (shift_en) q <= {q[BITS-2:0], ~pin_n};
  end
endmodule

// File: rtl/padrd_manual.sv
module padrd_manual (
  input  logic       clk,
  input  logic       rst,
  input  logic       busy,
  input  logic       latch_wr,
  input  logic       latch_wbit,
  input  logic [1:0] ser_rd,
  input  logic [1:0] pad1_data_n,
  input  logic [1:0] pad2_data_n,
  output logic       man_latch,
  output logic [1:0] man_clk,
  output logic [7:0] ser1_rdata,
  output logic [7:0] ser2_rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      man_latch  <= 1'b0;
      man_clk    <= '0;
      ser1_rdata <= '0;
      ser2_rdata <= '0;
    end else begin
      man_clk <= ser_rd & {2{~busy}};
      if (latch_wr && !busy) man_latch <= latch_wbit;
      if (ser_rd[0] && !busy) ser1_rdata <= {6'b000000, ~pad1_data_n};
      if (ser_rd[1] && !busy) ser2_rdata <= {3'b000, 3'b111, ~pad2_data_n};
    end
  end
endmodule

// File: rtl/pad_autoread.sv
module pad_autoread
  import padrd_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int BITS     = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            vblank_start,
  input  logic            autoread_en,
  input  logic            latch_wr,
  input  logic            latch_wbit,
  input  logic [1:0]      ser_rd,
  input  logic [1:0]      pad1_data_n,
  input  logic [1:0]      pad2_data_n,
  output logic            pad_latch,
  output logic [1:0]      pad_clk,
  output logic            busy,
  output logic [BITS-1:0] res_p1_l1,
  output logic [BITS-1:0] res_p2_l1,
  output logic [BITS-1:0] res_p1_l2,
  output logic [BITS-1:0] res_p2_l2,
  output logic [7:0]      ser1_rdata,
  output logic [7:0]      ser2_rdata
);
  logic            seq_latch, seq_clk, sample;
  logic            man_latch;
  logic [1:0]      man_clk;
  logic [NUM_LANES-1:0] lane_pin_n;
  logic [BITS-1:0] lane_q [NUM_LANES];

  padrd_seq #(.HALF_CYC(HALF_CYC), .BITS(BITS)) u_seq (
    .clk(clk), .rst(rst), .trigger(vblank_start), .enable(autoread_en),
    .busy(busy), .seq_latch(seq_latch), .seq_clk(seq_clk), .sample(sample)
  );

  padrd_manual u_man (
    .clk(clk), .rst(rst), .busy(busy),
    .latch_wr(latch_wr), .latch_wbit(latch_wbit), .ser_rd(ser_rd),
    .pad1_data_n(pad1_data_n), .pad2_data_n(pad2_data_n),
    .man_latch(man_latch), .man_clk(man_clk),
    .ser1_rdata(ser1_rdata), .ser2_rdata(ser2_rdata)
  );

  // lane order fixes the result mapping: line 1 of both ports, then line 2
  assign lane_pin_n = {pad2_data_n[1], pad1_data_n[1], pad2_data_n[0], pad1_data_n[0]};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    padrd_lane #(.BITS(BITS)) u_lane (
      .clk(clk), .rst(rst), .shift_en(sample),
      .pin_n(lane_pin_n[g]), .q(lane_q[g])
    );
  end

  assign res_p1_l1 = lane_q[0];
  assign res_p2_l1 = lane_q[1];
  assign res_p1_l2 = lane_q[2];
  assign res_p2_l2 = lane_q[3];

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_latch <= 1'b0;
      pad_clk   <= '0;
    end else begin
      pad_latch <= busy ? seq_latch : man_latch;
      pad_clk   <= busy ? {2{seq_clk}} : man_clk;
    end
  end
endmodule

// File: rtl/pad_autoread_checker.sv
module pad_autoread_checker #(
  parameter int HALF_CYC = 4,
  parameter int BITS     = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       vblank_start,
  input logic       autoread_en,
  input logic [1:0] ser_rd,
  input logic       busy,
  input logic       pad_latch,
  input logic [1:0] pad_clk,
  input logic [7:0] ser1_rdata,
  input logic [7:0] ser2_rdata
);
  localparam int BUSY_CYC = 2 * HALF_CYC + BITS * (2 * HALF_CYC + 1);

  logic [31:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1;
    else           busy_len <= '0;
  end

  AST_BUSY_START: assert property (@(posedge clk) disable iff (rst)
    (vblank_start && autoread_en && !busy) |=> busy); // R1
  AST_NO_START: assert property (@(posedge clk) disable iff (rst)
    (!busy && !(vblank_start && autoread_en)) |=> !busy); // R1
  AST_CLK_PARALLEL: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> (pad_clk[0] == pad_clk[1])); // R2
  AST_LATCH_CLK_EXCL: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> !(pad_latch && (pad_clk != 2'b00))); // R2
  AST_BUSY_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == 32'(BUSY_CYC))); // R6
  AST_P2_FIXED_BITS: assert property (@(posedge clk) disable iff (rst)
    (ser_rd[1] && !busy) |=> (ser2_rdata[7:2] == 6'b000111)); // R8
  AST_RD_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && ser_rd[0]) |=> $stable(ser1_rdata)); // R10
endmodule

bind pad_autoread pad_autoread_checker #(.HALF_CYC(HALF_CYC), .BITS(BITS)) u_chk (
  .clk(clk), .rst(rst), .vblank_start(vblank_start), .autoread_en(autoread_en),
  .ser_rd(ser_rd), .busy(busy), .pad_latch(pad_latch), .pad_clk(pad_clk),
  .ser1_rdata(ser1_rdata), .ser2_rdata(ser2_rdata)
);

// File: tb/pad_autoread_bench.sv
module pad_autoread_bench;
  localparam int H = 4;
  localparam int B = 16;
  localparam int BUSY_EXP = 2 * H + B * (2 * H + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vblank_start = 1'b0, autoread_en = 1'b0, latch_wr = 1'b0, latch_wbit = 1'b0;
  logic [1:0] ser_rd = 2'b00;
  logic [1:0] pad1_data_n, pad2_data_n;
  logic pad_latch, busy;
  logic [1:0] pad_clk;
  logic [B-1:0] res_p1_l1, res_p2_l1, res_p1_l2, res_p2_l2;
  logic [7:0] ser1_rdata, ser2_rdata;

  always #2 clk = ~clk;

  pad_autoread #(.HALF_CYC(H), .BITS(B)) u_pad_autoread (
    .clk(clk), .rst(rst), .vblank_start(vblank_start), .autoread_en(autoread_en),
    .latch_wr(latch_wr), .latch_wbit(latch_wbit), .ser_rd(ser_rd),
    .pad1_data_n(pad1_data_n), .pad2_data_n(pad2_data_n),
    .pad_latch(pad_latch), .pad_clk(pad_clk), .busy(busy),
    .res_p1_l1(res_p1_l1), .res_p2_l1(res_p2_l1),
    .res_p1_l2(res_p1_l2), .res_p2_l2(res_p2_l2),
    .ser1_rdata(ser1_rdata), .ser2_rdata(ser2_rdata)
  );

  // controller model: stream of 32 logical bits per line, pins active low
  logic [31:0] pat [2][2];
  int idx0 = 0, idx1 = 0;
  logic prev0 = 1'b0, prev1 = 1'b0;

  always @(negedge clk) begin
    if (pad_latch) begin
      idx0 <= 0;
      idx1 <= 0;
    end else begin
      if (pad_clk[0] && !prev0) idx0 <= idx0 + 1;
      if (pad_clk[1] && !prev1) idx1 <= idx1 + 1;
    end
    prev0 <= pad_clk[0];
    prev1 <= pad_clk[1];
  end

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      pad1_data_n[l] = (idx0 < 32) ? ~pat[0][l][31 - idx0] : 1'b0;
      pad2_data_n[l] = (idx1 < 32) ? ~pat[1][l][31 - idx1] : 1'b0;
    end
  end

  // monitors
  int busy_cnt = 0, latch_hi = 0, rise0 = 0, rise1 = 0;
  logic mp0 = 1'b0, mp1 = 1'b0;
  always @(negedge clk) begin
    if (busy) busy_cnt <= busy_cnt + 1;
    if (pad_latch) latch_hi <= latch_hi + 1;
    if (pad_clk[0] && !mp0) rise0 <= rise0 + 1;
    if (pad_clk[1] && !mp1) rise1 <= rise1 + 1;
    mp0 <= pad_clk[0];
    mp1 <= pad_clk[1];
  end

  int n_checks = 0, n_err = 0;
  int mpos [2];
  logic done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    @(negedge clk);
    busy_cnt = 0; latch_hi = 0; rise0 = 0; rise1 = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic check_results();
    check("R3 R4 R5 port1 line1", 32'(res_p1_l1), 32'(pat[0][0][31:16]));
    check("R3 R4 R5 port2 line1", 32'(res_p2_l1), 32'(pat[1][0][31:16]));
    check("R3 R4 R5 port1 line2", 32'(res_p1_l2), 32'(pat[0][1][31:16]));
    check("R3 R4 R5 port2 line2", 32'(res_p2_l2), 32'(pat[1][1][31:16]));
    check("R6 busy length", 32'(busy_cnt), 32'(BUSY_EXP));
    check("R2 latch high cycles", 32'(latch_hi), 32'(H));
    check("R2 port1 clocks", 32'(rise0), 32'(B));
    check("R2 port2 clocks", 32'(rise1), 32'(B));
    mpos[0] = B;
    mpos[1] = B;
  endtask

  task automatic man_read(input int p, input string req);
    logic [7:0] exp;
    @(negedge clk) ser_rd[p] = 1'b1;
    @(negedge clk) ser_rd = 2'b00;
    exp = {6'b0, pat[p][1][31 - mpos[p]], pat[p][0][31 - mpos[p]]};
    if (p == 1) exp[4:2] = 3'b111;
    check(req, 32'(p == 0 ? ser1_rdata : ser2_rdata), 32'(exp));
    mpos[p]++;
    repeat (3) @(negedge clk);
  endtask

  task automatic start_frame();
    @(negedge clk) vblank_start = 1'b1;
    @(negedge clk) vblank_start = 1'b0;
    check("R1 busy after trigger", 32'(busy), 32'd1);
  endtask

  initial begin
    for (int p = 0; p < 2; p++)
      for (int l = 0; l < 2; l++) pat[p][l] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check("R11 busy", 32'(busy), 0);
    check("R11 latch/clk", 32'({pad_latch, pad_clk}), 0);
    check("R11 results", 32'(res_p1_l1 | res_p2_l1 | res_p1_l2 | res_p2_l2), 0);
    check("R11 read regs", 32'({ser1_rdata, ser2_rdata}), 0);

    // R9 manual latch
    @(negedge clk) begin latch_wr = 1'b1; latch_wbit = 1'b1; end
    @(negedge clk) latch_wr = 1'b0;
    @(negedge clk);
    check("R9 latch set", 32'(pad_latch), 1);
    @(negedge clk) begin latch_wr = 1'b1; latch_wbit = 1'b0; end
    @(negedge clk) latch_wr = 1'b0;
    @(negedge clk);
    check("R9 latch clear", 32'(pad_latch), 0);
    mpos[0] = 0;
    mpos[1] = 0;
    man_read(0, "R8 port1 manual read after latch");
    man_read(1, "R8 port2 manual read after latch");
    check("R8 single clock per read", 32'({rise1 > 0, rise0 > 0}), 32'h3);

    // pattern sweep
    autoread_en = 1'b1;
    for (int f = 0; f < 24; f++) begin
      for (int p = 0; p < 2; p++)
        for (int l = 0; l < 2; l++) begin
          if (f == 0)      pat[p][l] = 32'h0;
          else if (f == 1) pat[p][l] = 32'hFFFF_FFFF;
          else if (f < 6)  pat[p][l] = 32'h1 << (16 + ((f - 2) * 4 + p * 2 + l) % 16);
          else             pat[p][l] = (32'(f) * 32'h9E37_79B9) ^ (32'(p * 2 + l) * 32'h85EB_CA6B) ^ 32'h5A5A_3C3C;
        end
      clr_mon();
      start_frame();
      wait_idle();
      check_results();
      check("R7 latch stays low", 32'(pad_latch), 0);
      man_read(0, "R7 R8 port1 continues stream");
      man_read(1, "R7 R8 port2 continues stream");
      man_read(0, "R7 R8 port1 second bit");
    end

    // R1 disabled trigger
    autoread_en = 1'b0;
    pat[0][0] = 32'hAAAA_0000;
    clr_mon();
    @(negedge clk) vblank_start = 1'b1;
    @(negedge clk) vblank_start = 1'b0;
    repeat (200) @(negedge clk);
    check("R1 disabled no busy", 32'(busy_cnt), 0);
    check("R1 disabled results kept", 32'(res_p1_l1 == 16'hAAAA), 0);

    // R10 accesses during busy
    autoread_en = 1'b1;
    pat[0][0] = 32'h1234_5678; pat[0][1] = 32'hCAFE_F00D;
    pat[1][0] = 32'h0F0F_9999; pat[1][1] = 32'h8001_4242;
    clr_mon();
    start_frame();
    repeat (20) @(negedge clk);
    begin
      logic [7:0] s1, s2;
      s1 = ser1_rdata; s2 = ser2_rdata;
      ser_rd = 2'b11; latch_wr = 1'b1; latch_wbit = 1'b1; vblank_start = 1'b1;
      @(negedge clk) begin ser_rd = 2'b00; latch_wr = 1'b0; latch_wbit = 1'b0; vblank_start = 1'b0; end
      check("R10 port1 read ignored", 32'(ser1_rdata), 32'(s1));
      check("R10 port2 read ignored", 32'(ser2_rdata), 32'(s2));
    end
    wait_idle();
    check_results();
    check("R10 latch write ignored", 32'(pad_latch), 0);
    man_read(0, "R10 R7 port1 stream not advanced");
    man_read(1, "R10 R7 port2 stream not advanced");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end
endmodule